// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the virtual program counter of an instruction fetch into a physical address. It also reports a fault code and loads two fault-capture registers when a fault occurs. Each request takes one of five routes:

- A PC with bit 0 set marks privileged firmware code and goes straight through with no translation.
- A PC outside the canonical sign-extended range is rejected.
- A kernel-only superpage window is mapped one-to-one onto physical space.
- Every other PC is sent to an external TLB as a page-number lookup.
- The TLB answer is checked for execute permission in the mode of the request.

Requests arrive on a valid/ready channel and results leave on another. Only one request is in flight at a time. `req_ready` is high only when the unit is idle. Once `rsp_valid` rises, the result stays frozen until `rsp_ready` is seen high at a clock edge. The TLB side is a one-cycle lookup pulse with no back-pressure. The lookup answer must arrive as a one-cycle `tlb_rsp_valid` pulse no earlier than the cycle after the lookup pulse.

Top module: `iatu`

## Requirements
- R1: If `req_pc[0]`=1, the result is fault code 0 (none) and `rsp_pa` = `req_pc[43:0]` with bits [1:0] cleared. `rsp_uncached`=0 and no TLB lookup is issued, even when the PC is not canonical.
- R2: If `req_pc[0]`=0 and `req_pc[63:42]` is neither all zeros nor all ones, the result is fault code 1 (access violation) and no lookup is issued.
- R3: If `sp_enable`=1, the PC is canonical and `req_pc[42:41]`=2'b10, a kernel request (mode 0) gets `rsp_pa` = `req_pc[39:0]` zero-extended to 44 bits. Such a request gets fault 0 and no lookup is issued. With `sp_enable`=0 the same PC takes the lookup route.
- R4: A superpage-window request whose mode is not kernel gets fault code 1. Modes are encoded kernel=0, executive=1, supervisor=2, user=3.
- R5: Every other request issues exactly one `tlb_req_valid` pulse with `tlb_req_vpn` = `req_pc[42:13]`. A TLB answer with `tlb_rsp_hit`=0 gives fault code 2 (miss).
- R6: On a permitted hit, `rsp_pa` = {`tlb_rsp_pfn`, `req_pc[12:2]`, 2'b00} and `rsp_uncached` equals bit 43 of that address.
- R7: A hit whose `tlb_rsp_xre` bit at the index of the request mode is 0 gives fault code 1.
- R8: On any fault with `req_misspec`=0, `cap_tag` takes the PC and `cap_fmt` takes `ptbr` OR (`req_pc[42:13]` << 3). Both are visible when `rsp_valid` rises.
- R9: A request with `req_misspec`=1 leaves `cap_tag` and `cap_fmt` unchanged, but still gets its normal response.
- R10: `req_ready` and `rsp_valid` are never high together. A stalled response holds all its fields stable. A faulting response carries `rsp_pa`=0 and `rsp_uncached`=0.
- R11: After reset `req_ready`=1, `rsp_valid`=0, `tlb_req_valid`=0, and both capture registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Unit idle, request accepted at this edge |
| req_pc | input | 64 | Virtual PC of the fetch |
| req_mode | input | 2 | Current mode (0 kernel .. 3 user) |
| req_misspec | input | 1 | Request is on a misspeculated path |
| sp_enable | input | 1 | Superpage window enable |
| ptbr | input | 64 | Page-table base used for the formatted fault address |
| tlb_req_valid | output | 1 | One-cycle lookup pulse |
| tlb_req_vpn | output | 30 | Virtual page number to look up |
| tlb_rsp_valid | input | 1 | One-cycle lookup answer |
| tlb_rsp_hit | input | 1 | Matching entry found |
| tlb_rsp_pfn | input | 31 | Physical frame number |
| tlb_rsp_xre | input | 4 | Execute-enable bit per mode |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_pa | output | 44 | Physical address (0 on fault) |
| rsp_uncached | output | 1 | Address lies in uncached space |
| rsp_fault | output | 2 | 0 none, 1 access violation, 2 miss |
| cap_tag | output | 64 | Captured faulting PC |
| cap_fmt | output | 64 | Captured formatted page-table entry address |

## Verification
The hardest case to reach is the interaction of capture with misspeculation. A faulting misspeculated request must leave the registers exactly as the previous real fault set them. That only shows if an earlier fault loaded distinctive values and a different PC then faults with the flag set. The directed sequence therefore faults first with one PC and base, then issues a misspeculated fault with another PC and base. Random traffic mixes every route with random misspeculation, lookup latency and response stalls, all against a running model of the capture contents.

// File: rtl/iatu_pkg.sv
package iatu_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_ACV  = 2'd1,
    FLT_MISS = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_EXEC = 2'd1,
    MODE_SUPV = 2'd2,
    MODE_USER = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    PATH_BYPASS,
    PATH_BADVA,
    PATH_SP_OK,
    PATH_SP_DENY,
    PATH_LOOKUP
  } path_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_WAIT,
    ST_RESP
  } state_e;
endpackage

// File: rtl/iatu_classify.sv
module iatu_classify
  import iatu_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 43,
  parameter int PA_W    = 44,
  parameter int SP_PA_W = 40
) (
  input  logic [VA_W-1:0] pc,
  input  mode_e           mode,
  input  logic            sp_on,
  output path_e           path,
  output logic [PA_W-1:0] direct_pa
);
  localparam int HI_W = VA_W - VA_IMPL + 1;

  logic canon;
  logic in_window;

  generate
    if (VA_W > VA_IMPL) begin : g_canon
      logic [HI_W-1:0] hi;
      assign hi    = pc[VA_W-1:VA_IMPL-1];
      assign canon = (hi == '0) || (hi == '1);
    end else begin : g_full
      assign canon = 1'b1;
    end
  endgenerate

  assign in_window = (pc[VA_IMPL-1:VA_IMPL-2] == 2'b10);

  always_comb begin
    direct_pa = '0;
    if (pc[0]) begin
      path      = PATH_BYPASS;
      direct_pa = pc[PA_W-1:0] & ~PA_W'(3);
    end else if (!canon) begin
      path = PATH_BADVA;
    end else if (sp_on && in_window) begin
      if (mode == MODE_KERN) begin
        path = PATH_SP_OK;
        direct_pa[SP_PA_W-1:0] = pc[SP_PA_W-1:0];
      end else begin
        path = PATH_SP_DENY;
      end
    end else begin
      path = PATH_LOOKUP;
    end
  end
endmodule

// File: rtl/iatu_perm.sv
module iatu_perm
  import iatu_pkg::*;
#(
  parameter int PA_W      = 44,
  parameter int PAGE_BITS = 13,
  parameter int NUM_MODES = 4
) (
  input  logic [PA_W-PAGE_BITS-1:0] pfn,
  input  logic [PAGE_BITS-1:0]      pofs,
  input  logic [NUM_MODES-1:0]      xre,
  input  mode_e                     mode,
  input  logic                      hit,
  output fault_e                    fault,
  output logic [PA_W-1:0]           pa,
  output logic                      uncached
);
  logic [PA_W-1:0] full_pa;

  assign full_pa = {pfn, pofs} & ~PA_W'(3);

  always_comb begin
    pa       = '0;
    uncached = 1'b0;
    if (!hit) begin
      fault = FLT_MISS;
    end else if (!xre[mode]) begin
      fault = FLT_ACV;
    end else begin
      fault    = FLT_NONE;
      pa       = full_pa;
      uncached = full_pa[PA_W-1];
    end
  end
endmodule

// File: rtl/iatu_capture.sv
module iatu_capture #(
  parameter int VA_W  = 64,
  parameter int VPN_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             misspec,
  input  logic [VA_W-1:0]  pc,
  input  logic [VPN_W-1:0] vpn,
  input  logic [VA_W-1:0]  ptbr,
  output logic [VA_W-1:0]  tag,
  output logic [VA_W-1:0]  fmt
);
  logic [VA_W-1:0] vpn_scaled;

  assign vpn_scaled = {{(VA_W-VPN_W-3){1'b0}}, vpn, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag <= '0;
      fmt <= '0;
    end else if (load && !misspec) begin
      tag <= pc;
      fmt <= ptbr | vpn_scaled;
    end
  end

  assert_hold_on_misspec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && misspec) |=> ($stable(tag) && $stable(fmt)));

  assert_tag_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !misspec) |=> (tag == $past(pc)));
endmodule

// File: rtl/iatu.sv
module iatu
  import iatu_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int VA_IMPL   = 43,
  parameter int PA_W      = 44,
  parameter int PAGE_BITS = 13,
  parameter int SP_PA_W   = 40,
  parameter int NUM_MODES = 4,
  localparam int VPN_W    = VA_IMPL - PAGE_BITS,
  localparam int PFN_W    = PA_W - PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VA_W-1:0]      req_pc,
  input  logic [1:0]           req_mode,
  input  logic                 req_misspec,
  input  logic                 sp_enable,
  input  logic [VA_W-1:0]      ptbr,
  output logic                 tlb_req_valid,
  output logic [VPN_W-1:0]     tlb_req_vpn,
  input  logic                 tlb_rsp_valid,
  input  logic                 tlb_rsp_hit,
  input  logic [PFN_W-1:0]     tlb_rsp_pfn,
  input  logic [NUM_MODES-1:0] tlb_rsp_xre,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [PA_W-1:0]      rsp_pa,
  output logic                 rsp_uncached,
  output logic [1:0]           rsp_fault,
  output logic [VA_W-1:0]      cap_tag,
  output logic [VA_W-1:0]      cap_fmt
);
  state_e          state;
  logic [VA_W-1:0] cur_pc;
  mode_e           cur_mode;
  logic            cur_misspec;
  logic [PA_W-1:0] pa_q;
  logic            unc_q;
  fault_e          fault_q;

  path_e           path;
  logic [PA_W-1:0] direct_pa;
  fault_e          perm_fault;
  logic [PA_W-1:0] perm_pa;
  logic            perm_unc;
  fault_e          early_fault;
  logic            cap_load;

  iatu_classify #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_W(PA_W), .SP_PA_W(SP_PA_W)
  ) u_classify (
    .pc(cur_pc), .mode(cur_mode), .sp_on(sp_enable),
    .path(path), .direct_pa(direct_pa)
  );

  iatu_perm #(
    .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .NUM_MODES(NUM_MODES)
  ) u_perm (
    .pfn(tlb_rsp_pfn), .pofs(cur_pc[PAGE_BITS-1:0]), .xre(tlb_rsp_xre),
    .mode(cur_mode), .hit(tlb_rsp_hit),
    .fault(perm_fault), .pa(perm_pa), .uncached(perm_unc)
  );

  assign early_fault = (path == PATH_BADVA || path == PATH_SP_DENY) ? FLT_ACV : FLT_NONE;

  assign cap_load = (state == ST_DECIDE && early_fault != FLT_NONE) ||
                    (state == ST_WAIT && tlb_rsp_valid && perm_fault != FLT_NONE);

  iatu_capture #(.VA_W(VA_W), .VPN_W(VPN_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .load(cap_load), .misspec(cur_misspec),
    .pc(cur_pc), .vpn(cur_pc[VA_IMPL-1:PAGE_BITS]), .ptbr(ptbr),
    .tag(cap_tag), .fmt(cap_fmt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cur_pc      <= '0;
      cur_mode    <= MODE_KERN;
      cur_misspec <= 1'b0;
      pa_q        <= '0;
      unc_q       <= 1'b0;
      fault_q     <= FLT_NONE;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          cur_pc      <= req_pc;
          cur_mode    <= mode_e'(req_mode);
          cur_misspec <= req_misspec;
          state       <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (path == PATH_LOOKUP) begin
            state <= ST_WAIT;
          end else begin
            pa_q    <= direct_pa;
            unc_q   <= (path == PATH_SP_OK) && direct_pa[PA_W-1];
            fault_q <= early_fault;
            state   <= ST_RESP;
          end
        end
        ST_WAIT: if (tlb_rsp_valid) begin
          pa_q    <= perm_pa;
          unc_q   <= perm_unc;
          fault_q <= perm_fault;
          state   <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign rsp_valid     = (state == ST_RESP);
  assign rsp_pa        = pa_q;
  assign rsp_uncached  = unc_q;
  assign rsp_fault     = fault_q;
  assign tlb_req_valid = (state == ST_DECIDE) && (path == PATH_LOOKUP);
  assign tlb_req_vpn   = cur_pc[VA_IMPL-1:PAGE_BITS];

  assert_bypass_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && cur_pc[0]) |-> (rsp_fault == FLT_NONE && !rsp_uncached));

  assert_no_lookup_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req_valid |-> !cur_pc[0]);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault) && $stable(rsp_uncached)));

  assert_one_inflight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid);

  assert_fault_zero_pa_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_pa == '0 && !rsp_uncached));

  assert_miss_only_lookup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == FLT_MISS) |-> !cur_pc[0]);
endmodule

// File: tb/iatu_tb.sv
module iatu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_pc = '0;
  logic [1:0]  req_mode = '0;
  logic        req_misspec = 1'b0;
  logic        sp_enable = 1'b0;
  logic [63:0] ptbr = '0;
  logic        tlb_req_valid;
  logic [29:0] tlb_req_vpn;
  logic        tlb_rsp_valid = 1'b0;
  logic        tlb_rsp_hit = 1'b0;
  logic [30:0] tlb_rsp_pfn = '0;
  logic [3:0]  tlb_rsp_xre = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [43:0] rsp_pa;
  logic        rsp_uncached;
  logic [1:0]  rsp_fault;
  logic [63:0] cap_tag;
  logic [63:0] cap_fmt;

  int n_cmp = 0;
  int n_bad = 0;

  logic        t_hit;
  logic [30:0] t_pfn;
  logic [3:0]  t_xre;
  int          t_delay;
  logic        t_seen;
  logic [29:0] t_vpn;
  logic [63:0] exp_tag = '0;
  logic [63:0] exp_fmt = '0;

  always #2.5 clk = ~clk;

  iatu u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pc(req_pc), .req_mode(req_mode), .req_misspec(req_misspec),
    .sp_enable(sp_enable), .ptbr(ptbr),
    .tlb_req_valid(tlb_req_valid), .tlb_req_vpn(tlb_req_vpn),
    .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_hit(tlb_rsp_hit),
    .tlb_rsp_pfn(tlb_rsp_pfn), .tlb_rsp_xre(tlb_rsp_xre),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_uncached(rsp_uncached), .rsp_fault(rsp_fault),
    .cap_tag(cap_tag), .cap_fmt(cap_fmt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] pc, input logic [1:0] mode,
                                input logic sp, input logic hit, input logic [30:0] pfn,
                                input logic [3:0] xre, output logic [1:0] flt,
                                output logic [43:0] pa, output logic unc, output logic look);
    flt = 2'd0; pa = '0; unc = 1'b0; look = 1'b0;
    if (pc[0]) pa = pc[43:0] & ~44'h3;
    else if (!(pc[63:42] == '0 || pc[63:42] == '1)) flt = 2'd1;
    else if (sp && pc[42:41] == 2'b10) begin
      if (mode != 2'd0) flt = 2'd1;
      else pa = {4'h0, pc[39:0]};
    end else begin
      look = 1'b1;
      if (!hit) flt = 2'd2;
      else if (!xre[mode]) flt = 2'd1;
      else begin
        pa  = {pfn, pc[12:0]} & ~44'h3;
        unc = pa[43];
      end
    end
  endfunction

  // TLB responder: answers each lookup pulse after t_delay+1 cycles
  initial begin
    forever begin
      @(negedge clk);
      if (tlb_req_valid) begin
        t_seen = 1'b1;
        t_vpn  = tlb_req_vpn;
        repeat (t_delay + 1) @(negedge clk);
        tlb_rsp_valid = 1'b1;
        tlb_rsp_hit   = t_hit;
        tlb_rsp_pfn   = t_pfn;
        tlb_rsp_xre   = t_xre;
        @(negedge clk);
        tlb_rsp_valid = 1'b0;
      end
    end
  end

  task automatic run(input string tag, input logic [63:0] pc, input logic [1:0] mode,
                     input logic ms, input logic hit, input logic [30:0] pfn,
                     input logic [3:0] xre, input int dly, input int stall);
    logic [1:0]  e_flt;
    logic [43:0] e_pa;
    logic        e_unc;
    logic        e_look;
    logic [43:0] s_pa;
    logic [1:0]  s_flt;
    int          cnt;
    model(pc, mode, sp_enable, hit, pfn, xre, e_flt, e_pa, e_unc, e_look);
    if (e_flt != 2'd0 && !ms) begin
      exp_tag = pc;
      exp_fmt = ptbr | ({34'b0, pc[42:13]} << 3);
    end
    @(negedge clk);
    chk({tag, " R10 idle ready"}, 64'(req_ready), 64'd1);
    t_seen = 1'b0; t_hit = hit; t_pfn = pfn; t_xre = xre; t_delay = dly;
    req_pc = pc; req_mode = mode; req_misspec = ms; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0;
    while (!rsp_valid && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    chk({tag, " R10 rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " R1-7 fault"}, 64'(rsp_fault), 64'(e_flt));
    chk({tag, " R1 R3 R6 pa"}, 64'(rsp_pa), 64'(e_pa));
    chk({tag, " R6 uncached"}, 64'(rsp_uncached), 64'(e_unc));
    chk({tag, " R5 lookup issued"}, 64'(t_seen), 64'(e_look));
    if (e_look) chk({tag, " R5 vpn"}, 64'(t_vpn), 64'(pc[42:13]));
    chk({tag, " R8 R9 cap_tag"}, cap_tag, exp_tag);
    chk({tag, " R8 R9 cap_fmt"}, cap_fmt, exp_fmt);
    s_pa = rsp_pa; s_flt = rsp_fault;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk({tag, " R10 hold"}, {19'b0, rsp_valid, s_flt, rsp_pa}, {19'b0, 1'b1, rsp_fault, s_pa});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk({tag, " R10 released"}, 64'(rsp_valid), 64'd0);
  endtask

  function automatic logic [63:0] rnd_pc(input int kind);
    logic [63:0] v;
    v = {$urandom, $urandom};
    case (kind)
      0: v[0] = 1'b1;
      1: begin v[63:42] = 22'h2AAAA5; v[0] = 1'b0; end
      2: begin v[63:41] = {21'h1FFFFF, 2'b10}; v[0] = 1'b0; end
      default: begin v[63:42] = v[42] ? '1 : '0; v[0] = 1'b0; end
    endcase
    return v;
  endfunction

  initial begin
    void'($urandom(32'h1A7C_0051));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 req_ready", 64'(req_ready), 64'd1);
    chk("R11 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R11 tlb_req_valid", 64'(tlb_req_valid), 64'd0);
    chk("R11 cap_tag", cap_tag, 64'd0);
    chk("R11 cap_fmt", cap_fmt, 64'd0);
    rst_n = 1'b1;

    ptbr = 64'h0000_0040_0000_0000;
    sp_enable = 1'b1;
    // R1 bypass, non-canonical PC, stalled output
    run("R1", 64'h8123_4567_89AB_CDEF, 2'd3, 1'b0, 1'b1, 31'h1, 4'hF, 0, 3);
    // R2 bad VA
    run("R2", 64'h0100_0000_0000_2000, 2'd0, 1'b0, 1'b1, 31'h1, 4'hF, 0, 0);
    // R3 superpage kernel
    run("R3", 64'hFFFF_FC12_3456_7898, 2'd0, 1'b0, 1'b1, 31'h1, 4'hF, 0, 0);
    // R4 superpage user and executive
    run("R4", 64'hFFFF_FC00_0000_4000, 2'd3, 1'b0, 1'b1, 31'h1, 4'hF, 0, 0);
    run("R4", 64'hFFFF_FC00_0000_8000, 2'd1, 1'b0, 1'b1, 31'h1, 4'hF, 0, 0);
    // R3 window disabled -> lookup
    sp_enable = 1'b0;
    run("R3off", 64'hFFFF_FC00_0001_2344, 2'd3, 1'b0, 1'b1, 31'h12, 4'h8, 1, 0);
    sp_enable = 1'b1;
    // R5 miss
    run("R5", 64'h0000_0012_3456_0000, 2'd2, 1'b0, 1'b0, 31'h0, 4'hF, 2, 0);
    // R6 hit, uncached frame
    run("R6", 64'h0000_0000_0000_3FFE, 2'd0, 1'b0, 1'b1, 31'h4000_0001, 4'h1, 0, 2);
    // R7 permission per mode
    for (int m = 0; m < 4; m++) begin
      run("R7deny", 64'h0000_0001_0000_A000, 2'(m), 1'b0, 1'b1, 31'h77, ~(4'h1 << m), 0, 0);
      run("R7allow", 64'h0000_0001_0000_A004, 2'(m), 1'b0, 1'b1, 31'h77, 4'h1 << m, 0, 0);
    end
    // R8 real fault then R9 misspeculated fault with other PC and base
    ptbr = 64'h0000_0080_0000_0000;
    run("R8", 64'h0000_0003_0000_E000, 2'd1, 1'b0, 1'b0, 31'h0, 4'h0, 0, 0);
    ptbr = 64'h0000_00C0_0000_0000;
    run("R9", 64'h0100_0000_0000_0000, 2'd0, 1'b1, 1'b0, 31'h0, 4'h0, 0, 0);
    run("R9", 64'h0000_0005_0000_2000, 2'd0, 1'b1, 1'b0, 31'h0, 4'h0, 1, 0);

    for (int n = 0; n < 300; n++) begin
      sp_enable = 1'($urandom);
      ptbr = {$urandom, $urandom} & 64'hFFFF_FFFF_FFFF_E000;
      run("RND", rnd_pc($urandom_range(0, 5)), 2'($urandom), 1'($urandom_range(0, 3) == 0),
          1'($urandom_range(0, 4) != 0), 31'($urandom), 4'($urandom),
          $urandom_range(0, 3), $urandom_range(0, 2));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule